// File: doc/BRIEF.md
# Lane-Masked Single-Write Single-Read RAM

This block is a parameterized word memory with one write port and one read port, both on one clock. The write port takes one enable bit per lane, and a lane is `LANE_W` bits wide. A write stores only the lanes whose enable bit is set, so a caller can update one byte or one field of a word without reading the word first.

The read port is chosen at elaboration with two bit parameters:
- **Transparent synchronous read** (the default). The read is registered. A read of a word that is being written in the same cycle returns the word with the new lanes merged in.
- **Non-transparent synchronous read.** The read is registered and is controlled by a read enable. A read of a word that is being written in the same cycle returns the old contents.
- **Combinational read.** The output always follows the current contents of the addressed word.

Initial contents can be given as a packed parameter vector, and illegal geometry or mode combinations stop elaboration.

Top module: `lane_ram`

## Requirements
- R1: On a rising edge, for each set bit i of `wr_lane_en`, bits `[i*LANE_W +: LANE_W]` of `wr_data` are stored into those bits of word `wr_addr`. Bit 0 selects the least significant lane. Lanes whose bit is clear keep their contents, and an all-zero mask changes nothing.
- R2: `LANE_W` defaults to `DATA_W`. This gives a single enable bit that writes the whole word.
- R3: With `RD_ASYNC=0` and `RD_TRANSPARENT=1`, `rd_data` is registered. One edge after `rd_addr` is presented, it shows that word including any lanes written at the same edge.
- R4: In the transparent mode, `rd_en` has no effect, and the output updates every cycle.
- R5: With `RD_ASYNC=0` and `RD_TRANSPARENT=0`, an edge with `rd_en=1` loads `rd_data` with the addressed word as it was before that edge's write. A same-cycle write to the same address shows the old contents.
- R6: In the non-transparent mode, an edge with `rd_en=0` leaves `rd_data` unchanged.
- R7: With `RD_ASYNC=1`, `rd_data` shows the current contents of word `rd_addr` without a clock. A write becomes visible right after its edge.
- R8: A synchronous active-high `rst` clears the registered `rd_data` to zero in both synchronous modes. The memory contents survive reset.
- R9: Word k starts with `INIT_WORDS[k*DATA_W +: DATA_W]` for k < `INIT_COUNT`. All other words start at zero.
- R10: Elaboration fails in any of these cases:
  - `LANE_W` is zero, exceeds `DATA_W`, or does not divide `DATA_W`.
  - `DEPTH` is not a power of two of at least 2.
  - `INIT_COUNT` is outside 0..`DEPTH`.
  - `RD_ASYNC=1` is combined with `RD_TRANSPARENT=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the read register |
| wr_addr | input | ADDR_W = clog2(DEPTH) | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_lane_en | input | DATA_W/LANE_W | Per-lane write enables, bit 0 for the low lane |
| rd_addr | input | ADDR_W | Read word address |
| rd_en | input | 1 | Read enable, used only by the non-transparent mode |
| rd_data | output | DATA_W | Read data |

## Verification
A lane written from the wrong slice, or a lane that leaks into its neighbour, shows up at the first read of that word. In the transparent and combinational modes, that read comes on the edge of the write itself. A wrong bypass choice shows as old data where new data was due (transparent mode) or new data where old was due (non-transparent mode), one edge after the colliding cycle. A read register that moves while its enable is low differs from the held value on the very next edge. Three read-mode instances and one whole-word instance run against a shared reference array. The stimulus uses tabled and random lane masks, with addresses kept close together so that collisions are frequent.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

  function automatic bit lane_geometry_ok(int data_w, int lane_w);
    return (lane_w > 0) && (lane_w <= data_w) && ((data_w % lane_w) == 0);
  endfunction

  function automatic bit depth_ok(int depth);
    return (depth >= 2) && ((depth & (depth - 1)) == 0);
  endfunction

  function automatic bit init_count_ok(int count, int depth);
    return (count >= 0) && (count <= depth);
  endfunction

  function automatic bit read_mode_ok(bit async_rd, bit transparent);
    return !async_rd || transparent;
  endfunction

endpackage

// File: rtl/lane_ram_store.sv
module lane_ram_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 16,
  parameter int LANE_W = 8,
  parameter int INIT_COUNT = 0,
  parameter logic [DEPTH*DATA_W-1:0] INIT_WORDS = '0,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES = (LANE_W > 0) ? DATA_W / LANE_W : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lane_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Contents at elaboration: listed words, zeros beyond the count.
  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = (k < INIT_COUNT) ? INIT_WORDS[k*DATA_W +: DATA_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_lane_en[i]) begin
        mem[wr_addr][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_word = mem[rd_addr];

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R1
    lane_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_lane_en[g] |=> mem[$past(wr_addr)][g*LANE_W +: LANE_W] == $past(wr_data[g*LANE_W +: LANE_W]));
    // R1
    lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_lane_en[g] |=> mem[$past(wr_addr)][g*LANE_W +: LANE_W] == $past(mem[wr_addr][g*LANE_W +: LANE_W]));
  end

endmodule

// File: rtl/lane_ram_rdport.sv
module lane_ram_rdport #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8,
  parameter bit RD_ASYNC = 1'b0,
  parameter bit RD_TRANSPARENT = 1'b1,
  localparam int LANES = (LANE_W > 0) ? DATA_W / LANE_W : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lane_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] mem_word,
  output logic [DATA_W-1:0] rd_data
);

  if (RD_ASYNC) begin : g_comb
    logic sink_unused;
    assign sink_unused = ^{clk, rst, wr_addr, wr_data, wr_lane_en, rd_addr, rd_en};
    assign rd_data = mem_word;
  end else if (RD_TRANSPARENT) begin : g_fwd
    logic              hit;
    logic              rd_en_unused;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] rd_q;

    assign rd_en_unused = rd_en;
    assign hit = (wr_addr == rd_addr);

    always_comb begin
      for (int i = 0; i < LANES; i++) begin
        merged[i*LANE_W +: LANE_W] = (hit && wr_lane_en[i]) ? wr_data[i*LANE_W +: LANE_W]
                                                             : mem_word[i*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) rd_q <= '0;
      else     rd_q <= merged;
    end
    assign rd_data = rd_q;

    // R8
    fwd_reset_chk: assert property (@(posedge clk) rst |=> rd_data == '0);
    // R3
    fwd_new_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_addr == rd_addr && (&wr_lane_en)) |=> rd_data == $past(wr_data));
  end else begin : g_hold
    logic              sink_unused;
    logic [DATA_W-1:0] rd_q;

    assign sink_unused = ^{wr_addr, wr_data, wr_lane_en, rd_addr};

    always_ff @(posedge clk) begin
      if (rst)        rd_q <= '0;
      else if (rd_en) rd_q <= mem_word;
    end
    assign rd_data = rd_q;

    // R8
    hold_reset_chk: assert property (@(posedge clk) rst |=> rd_data == '0);
    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));
  end

endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 16,
  parameter int LANE_W = DATA_W,
  parameter bit RD_ASYNC = 1'b0,
  parameter bit RD_TRANSPARENT = 1'b1,
  parameter int INIT_COUNT = 0,
  parameter logic [DEPTH*DATA_W-1:0] INIT_WORDS = '0,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES = (LANE_W > 0) ? DATA_W / LANE_W : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_lane_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);

  // R10 elaboration-time legality
  if (!lane_ram_pkg::lane_geometry_ok(DATA_W, LANE_W)) begin : g_bad_lane
    $error("lane_ram: LANE_W must be positive, at most DATA_W, and divide DATA_W");
  end
  if (!lane_ram_pkg::depth_ok(DEPTH)) begin : g_bad_depth
    $error("lane_ram: DEPTH must be a power of two of at least 2");
  end
  if (!lane_ram_pkg::init_count_ok(INIT_COUNT, DEPTH)) begin : g_bad_init
    $error("lane_ram: INIT_COUNT must lie in 0..DEPTH");
  end
  if (!lane_ram_pkg::read_mode_ok(RD_ASYNC, RD_TRANSPARENT)) begin : g_bad_mode
    $error("lane_ram: a combinational read port is always transparent");
  end

  logic [DATA_W-1:0] mem_word;

  lane_ram_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LANE_W(LANE_W),
    .INIT_COUNT(INIT_COUNT), .INIT_WORDS(INIT_WORDS)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_en(wr_lane_en),
    .rd_addr(rd_addr), .rd_word(mem_word)
  );

  lane_ram_rdport #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W),
    .RD_ASYNC(RD_ASYNC), .RD_TRANSPARENT(RD_TRANSPARENT)
  ) u_rdport (
    .clk(clk), .rst(rst),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_en(wr_lane_en),
    .rd_addr(rd_addr), .rd_en(rd_en),
    .mem_word(mem_word), .rd_data(rd_data)
  );

endmodule

// File: tb/lane_ram_bench.sv
`timescale 1ns/1ps
module lane_ram_bench;

  localparam int DW = 8;
  localparam int DP = 16;
  localparam int LW = 2;
  localparam int LN = DW / LW;
  localparam logic [DP*DW-1:0] INIT = {96'h0, 32'hFFC3B2A1};

  // vector: {wr_addr[4], wr_data[8], lane_en[4], rd_addr[4], rd_en[1]}
  localparam logic [20:0] VEC [12] = '{
    {4'd3,  8'h5A, 4'hF, 4'd3,  1'b1},
    {4'd3,  8'hFF, 4'h5, 4'd3,  1'b1},
    {4'd7,  8'hC3, 4'hA, 4'd3,  1'b0},
    {4'd7,  8'h11, 4'h0, 4'd7,  1'b1},
    {4'd0,  8'h24, 4'h1, 4'd0,  1'b0},
    {4'd0,  8'h99, 4'h8, 4'd0,  1'b1},
    {4'd15, 8'hE7, 4'hF, 4'd15, 1'b1},
    {4'd15, 8'h00, 4'h6, 4'd1,  1'b1},
    {4'd1,  8'h3C, 4'hC, 4'd15, 1'b0},
    {4'd2,  8'h81, 4'h3, 4'd2,  1'b1},
    {4'd2,  8'h7E, 4'h0, 4'd2,  1'b0},
    {4'd9,  8'hAA, 4'hF, 4'd0,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [LN-1:0] wr_lane_en = '0;
  logic          word_en = 1'b0;
  logic [3:0]    rd_addr = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_tr, rd_nt, rd_as, rd_wd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model_mem [DP];
  logic [DW-1:0] exp_nt;
  logic [DW-1:0] exp_tr;

  always #2.5 clk = ~clk;

  lane_ram #(.DATA_W(DW), .DEPTH(DP), .LANE_W(LW), .RD_ASYNC(1'b0), .RD_TRANSPARENT(1'b1),
             .INIT_COUNT(3), .INIT_WORDS(INIT)) u_lane_ram (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_en(wr_lane_en),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_tr));

  lane_ram #(.DATA_W(DW), .DEPTH(DP), .LANE_W(LW), .RD_ASYNC(1'b0), .RD_TRANSPARENT(1'b0),
             .INIT_COUNT(3), .INIT_WORDS(INIT)) u_lane_ram_hold (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_en(wr_lane_en),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_nt));

  lane_ram #(.DATA_W(DW), .DEPTH(DP), .LANE_W(LW), .RD_ASYNC(1'b1), .RD_TRANSPARENT(1'b1),
             .INIT_COUNT(3), .INIT_WORDS(INIT)) u_lane_ram_comb (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_en(wr_lane_en),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_as));

  lane_ram #(.DATA_W(DW), .DEPTH(DP)) u_lane_ram_word (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_en(word_en),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_wd));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] wa, input logic [DW-1:0] wd, input logic [LN-1:0] le,
                      input logic [3:0] ra, input logic re);
    @(negedge clk);
    wr_addr = wa; wr_data = wd; wr_lane_en = le; rd_addr = ra; rd_en = re;
    if (re) exp_nt = model_mem[ra];
    for (int i = 0; i < LN; i++) begin
      if (le[i]) model_mem[wa][i*LW +: LW] = wd[i*LW +: LW];
    end
    exp_tr = model_mem[ra];
    @(posedge clk); #1;
    chk(re ? "R1 R3" : "R4", rd_tr, exp_tr);
    chk(re ? "R5" : "R6", rd_nt, exp_nt);
    chk("R7", rd_as, model_mem[ra]);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DP; k++) model_mem[k] = '0;
    model_mem[0] = 8'hA1; model_mem[1] = 8'hB2; model_mem[2] = 8'hC3;
    exp_nt = '0;

    // R8 reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R8", rd_tr, 8'h00);
    chk("R8", rd_nt, 8'h00);
    @(negedge clk) rst = 1'b0;

    // R9 initial contents, word 3 lies beyond the count
    for (int k = 0; k < 4; k++) begin
      step(4'd0, 8'h00, 4'h0, k[3:0], 1'b1);
      chk("R9", rd_tr, (k == 0) ? 8'hA1 : (k == 1) ? 8'hB2 : (k == 2) ? 8'hC3 : 8'h00);
    end

    // tabled vectors
    for (int v = 0; v < 12; v++) begin
      step(VEC[v][20:17], VEC[v][16:9], VEC[v][8:5], VEC[v][4:1], VEC[v][0]);
    end

    // R1 explicit lane merge: word 3 = 5A then lanes 0,2 of FF -> 7B
    step(4'd0, 8'h00, 4'h0, 4'd3, 1'b1);
    chk("R1", rd_tr, 8'h7B);

    // R8 mid-run reset keeps contents
    @(negedge clk);
    rst = 1'b1; wr_lane_en = '0;
    @(posedge clk); #1;
    chk("R8", rd_tr, 8'h00);
    chk("R8", rd_nt, 8'h00);
    exp_nt = '0;
    @(negedge clk) rst = 1'b0;
    step(4'd0, 8'h00, 4'h0, 4'd3, 1'b1);
    chk("R8", rd_nt, 8'h7B);

    // R2 whole-word instance with default lane width
    @(negedge clk);
    wr_addr = 4'd5; wr_data = 8'h6D; word_en = 1'b1; wr_lane_en = '0; rd_addr = 4'd5;
    @(posedge clk); #1;
    chk("R2", rd_wd, 8'h6D);
    @(negedge clk);
    wr_data = 8'h00; word_en = 1'b0;
    @(posedge clk); #1;
    chk("R2", rd_wd, 8'h6D);

    // R10 legality rules
    chk("R10", {7'd0, lane_ram_pkg::lane_geometry_ok(8, 3)}, 8'h00);
    chk("R10", {7'd0, lane_ram_pkg::lane_geometry_ok(8, 10)}, 8'h00);
    chk("R10", {7'd0, lane_ram_pkg::lane_geometry_ok(8, 2)}, 8'h01);
    chk("R10", {7'd0, lane_ram_pkg::read_mode_ok(1'b1, 1'b0)}, 8'h00);
    chk("R10", {7'd0, lane_ram_pkg::init_count_ok(17, 16)}, 8'h00);
    chk("R10", {7'd0, lane_ram_pkg::depth_ok(12)}, 8'h00);

    // random lane masks over a narrow address window
    for (int n = 0; n < 300; n++) begin
      step(4'($urandom_range(0, 3)), 8'($urandom), 4'($urandom), 4'($urandom_range(0, 3)),
           1'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule